// File: doc/BRIEF.md
# Event Status, Halt and Reset Controller

This block gathers completion and fault events from two bus engines into a single 32-bit status word. Each engine has two command queues. A 32-bit enable word selects which status bits drive the one interrupt line. Software acknowledges events in two ways: a per-bit write-one-to-clear, or a global clear command that empties the whole word. An event that arrives in the same cycle as a clear always survives the clear.

The block also runs the quiesce handshake for each engine. A halt is requested either by software or automatically by any fault event of that engine. The request is held on `halt_req` until the engine reports idle. The acknowledge then lands in the status word. Software may also issue reset commands to selected sub-blocks. If a reset touches an engine whose halt is still outstanding, the reset is held back until that halt has been acknowledged. Each applied reset raises a reset-done event.

Top module: `evc_ctrl`

## Requirements
- R1: A one-cycle event sets its status bit at the next clock edge, at these positions. Read done of engine 0 is bit 0 and of engine 1 is bit 12. Queue reports are bits 4 and 8 for engine 0 queues 0 and 1, and bits 16 and 20 for engine 1. The eight other fault inputs of engine 0 (`misc_err[7:0]`, index 0 to 7) map to bits 1, 2, 5, 6, 7, 9, 10 and 11. Those of engine 1 (`misc_err[15:8]`) map to the same positions plus 12.
- R2: No-acknowledge faults set bit 27 (engine 0 queue 0), bit 28 (engine 0 queue 1), bit 29 (engine 1 queue 0) and bit 30 (engine 1 queue 1). `nack_err` index 2*engine+queue selects the fault.
- R3: A write to the clear port clears exactly the status bits written as 1. All other bits keep their value.
- R4: A status bit that is set by an event in the same cycle as a clear of that bit is set after the edge.
- R5: A global clear command with its bit at 1 clears every status bit, except bits whose event arrives in the same cycle. With its bit at 0 it changes nothing.
- R6: `irq` is high exactly when some status bit is 1 and its enable bit is 1. Status bits record events whatever the enable word holds, and the enable word resets to 0.
- R7: A halt write with `halt_wdata[m]`=1 raises `halt_req[m]` after the next edge. While `eng_idle[m]` is 0 the request holds and no acknowledge appears. At the first edge with `eng_idle[m]`=1, status bit 25+m is set and `halt_req[m]` falls.
- R8: A halt requested for an engine that is already idle sets its acknowledge bit two edges after the write edge.
- R9: Any fault event of engine m (its `misc_err` or `nack_err` inputs) raises `halt_req[m]` at the same edge that records the fault.
- R10: A reset command keeps only the bits in 0x0f73f3f7. When the command is not held back, `blk_reset` shows that value for exactly one cycle, starting two edges after the write edge. Status bit 24 is set at the edge after the pulse. A command with no valid bits causes neither a pulse nor bit 24.
- R11: Bits 4 to 9 of a reset command belong to engine 0, and bits 12 to 17 belong to engine 1. A pending reset that touches an engine whose `halt_req` is high is held back. It is applied at the edge after that halt is acknowledged. A reset that touches only other engines is not held back.
- R12: Status bits 3, 15 and 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_we | input | 1 | Write strobe for the interrupt enable word |
| mask_wdata | input | 32 | New interrupt enable word |
| clr_we | input | 1 | Write strobe for the per-bit clear |
| clr_wdata | input | 32 | Bits to clear (1 = clear) |
| gclr_we | input | 1 | Write strobe for the global clear command |
| gclr_bit | input | 1 | Global clear command value; 1 clears all |
| halt_we | input | 1 | Write strobe for halt requests |
| halt_wdata | input | 2 | Bit m requests a halt of engine m |
| rst_we | input | 1 | Write strobe for the reset command |
| rst_wdata | input | 32 | Sub-block reset selection |
| rd_done | input | 2 | Read-done event per engine |
| q_report | input | 4 | Queue report event, index 2*engine+queue |
| nack_err | input | 4 | No-acknowledge fault, index 2*engine+queue |
| misc_err | input | 16 | Other faults, 8 per engine |
| eng_idle | input | 2 | Engine m is quiescent |
| halt_req | output | 2 | Halt request held toward each engine |
| blk_reset | output | 32 | One-cycle sub-block reset pulse |
| status | output | 32 | Event status word |
| irq | output | 1 | Interrupt line |

## Verification
Two of the block's functions can act on the same status bit in one cycle. In the first case, an event source fires in the same cycle as a per-bit clear or a global clear of that bit. The bench provokes this by driving a read-done event together with a clear of bit 0. It also drives a queue report together with a clear of a different bit, and it checks that the set wins only for the bit being set. In the second case, a halt acknowledge falls in the same cycle as a held-back reset. The bench raises the engine's idle while a reset for that engine waits. It then checks that the reset pulse appears exactly one edge after the acknowledge, and never earlier. It also checks that a reset for the other engine is not delayed.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int unsigned WORD_W        = 32;
    localparam int unsigned N_ENG         = 2;
    localparam int unsigned N_QUE         = 2;
    localparam int unsigned N_MISC        = 8;
    localparam int unsigned ENG_STRIDE    = 12;
    localparam int unsigned RD_OFS        = 0;
    localparam int unsigned QUE_OFS       = 4;
    localparam int unsigned QUE_STRIDE    = 4;
    localparam int unsigned RST_DONE_BIT  = 24;
    localparam int unsigned HALT_ACK_BASE = 25;
    localparam int unsigned NACK_BASE     = 27;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t RST_VALID = 32'h0f73_f3f7;
    localparam word_t RST_ENG0  = 32'h0000_03f0;

    // Reset bits owned by engine m (engine 1 sits one stride above engine 0)
    function automatic word_t eng_rst_bits(input int unsigned m);
        return RST_ENG0 << (ENG_STRIDE * m);
    endfunction

    // Position, inside one engine's slice, of its k-th miscellaneous fault
    function automatic int unsigned misc_pos(input int unsigned k);
        if (k < 2)      return k + 1;
        else if (k < 5) return k + 3;
        else            return k + 4;
    endfunction

endpackage

// File: rtl/evc_status.sv
module evc_status
    import evc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_ENG-1:0]        rd_done_i,
    input  logic [N_ENG*N_QUE-1:0]  qrep_i,
    input  logic [N_ENG*N_QUE-1:0]  nack_i,
    input  logic [N_ENG*N_MISC-1:0] misc_err_i,
    input  logic [N_ENG-1:0]        halt_ack_i,
    input  logic                    rst_done_i,
    input  logic                    mask_we_i,
    input  word_t                   mask_data_i,
    input  logic                    clr_we_i,
    input  word_t                   clr_data_i,
    input  logic                    gclr_we_i,
    input  logic                    gclr_bit_i,
    output word_t                   status_o,
    output logic                    irq_o
);

    typedef struct packed {
        word_t status;
        word_t mask;
    } st_t;

    st_t   st_d, st_q;
    word_t set_vec;
    word_t clr_vec;

    always_comb begin
        set_vec = '0;
        for (int m = 0; m < N_ENG; m++) begin
            set_vec[m*ENG_STRIDE + RD_OFS] = rd_done_i[m];
            for (int q = 0; q < N_QUE; q++) begin
                set_vec[m*ENG_STRIDE + QUE_OFS + q*QUE_STRIDE] = qrep_i[m*N_QUE + q];
                set_vec[NACK_BASE + m*N_QUE + q]               = nack_i[m*N_QUE + q];
            end
            for (int k = 0; k < N_MISC; k++) begin
                set_vec[m*ENG_STRIDE + misc_pos(k)] = misc_err_i[m*N_MISC + k];
            end
            set_vec[HALT_ACK_BASE + m] = halt_ack_i[m];
        end
        set_vec[RST_DONE_BIT] = rst_done_i;

        clr_vec = '0;
        if (clr_we_i)                clr_vec = clr_vec | clr_data_i;
        if (gclr_we_i && gclr_bit_i) clr_vec = '1;

        st_d        = st_q;
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
        if (mask_we_i) st_d.mask = mask_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & st_q.mask);

    a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_i[0] |=> status_o[0]);

    a_r3_clear_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_data_i[QUE_OFS] && !qrep_i[0]) |=> !status_o[QUE_OFS]);

    a_r5_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (gclr_we_i && gclr_bit_i && set_vec == '0) |=> status_o == '0);

    a_r10_done_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done_i |=> status_o[RST_DONE_BIT]);

endmodule

// File: rtl/evc_halt.sv
module evc_halt
    import evc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_we_i,
    input  logic [N_ENG-1:0] req_data_i,
    input  logic [N_ENG-1:0] err_hit_i,
    input  logic [N_ENG-1:0] idle_i,
    output logic [N_ENG-1:0] req_o,
    output logic [N_ENG-1:0] ack_o
);

    typedef struct packed {
        logic [N_ENG-1:0] pend;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        ack_o   = hs_q.pend & idle_i;
        hs_d    = hs_q;
        hs_d.pend = (hs_q.pend & ~ack_o) | err_hit_i;
        if (req_we_i) hs_d.pend = hs_d.pend | req_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign req_o = hs_q.pend;

    for (genvar m = 0; m < N_ENG; m++) begin : g_chk
        a_r7_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[m] && idle_i[m] && !(req_we_i && req_data_i[m]) && !err_hit_i[m])
            |=> !req_o[m]);

        a_r9_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
            err_hit_i[m] |=> req_o[m]);
    end

endmodule

// File: rtl/evc_reset.sv
module evc_reset
    import evc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we_i,
    input  word_t            cmd_data_i,
    input  logic [N_ENG-1:0] halt_busy_i,
    output word_t            pulse_o,
    output logic             done_o
);

    typedef struct packed {
        word_t pend;
        word_t pulse;
    } rs_t;

    rs_t  rs_d, rs_q;
    logic held;

    always_comb begin
        held = 1'b0;
        for (int m = 0; m < N_ENG; m++) begin
            if (((rs_q.pend & eng_rst_bits(m)) != '0) && halt_busy_i[m]) held = 1'b1;
        end

        rs_d = rs_q;
        if (held) begin
            rs_d.pulse = '0;
        end else begin
            rs_d.pulse = rs_q.pend;
            rs_d.pend  = '0;
        end
        if (cmd_we_i) rs_d.pend = rs_d.pend | (cmd_data_i & RST_VALID);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign pulse_o = rs_q.pulse;
    assign done_o  = |rs_q.pulse;

    for (genvar m = 0; m < N_ENG; m++) begin : g_chk
        a_r11_wait_for_halt: assert property (@(posedge clk) disable iff (!rst_n)
            (((rs_q.pend & eng_rst_bits(m)) != '0) && halt_busy_i[m])
            |=> ((pulse_o & eng_rst_bits(m)) == '0));
    end

endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl
    import evc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mask_we,
    input  logic [31:0] mask_wdata,
    input  logic        clr_we,
    input  logic [31:0] clr_wdata,
    input  logic        gclr_we,
    input  logic        gclr_bit,
    input  logic        halt_we,
    input  logic [1:0]  halt_wdata,
    input  logic        rst_we,
    input  logic [31:0] rst_wdata,
    input  logic [1:0]  rd_done,
    input  logic [3:0]  q_report,
    input  logic [3:0]  nack_err,
    input  logic [15:0] misc_err,
    input  logic [1:0]  eng_idle,
    output logic [1:0]  halt_req,
    output logic [31:0] blk_reset,
    output logic [31:0] status,
    output logic        irq
);

    logic [N_ENG-1:0] err_hit;
    logic [N_ENG-1:0] halt_ack;
    logic             rst_done;

    for (genvar m = 0; m < N_ENG; m++) begin : g_err
        assign err_hit[m] = (|misc_err[m*N_MISC +: N_MISC]) | (|nack_err[m*N_QUE +: N_QUE]);
    end

    evc_halt u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_we_i   (halt_we),
        .req_data_i (halt_wdata),
        .err_hit_i  (err_hit),
        .idle_i     (eng_idle),
        .req_o      (halt_req),
        .ack_o      (halt_ack)
    );

    evc_reset u_reset (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we_i    (rst_we),
        .cmd_data_i  (rst_wdata),
        .halt_busy_i (halt_req),
        .pulse_o     (blk_reset),
        .done_o      (rst_done)
    );

    evc_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_done_i   (rd_done),
        .qrep_i      (q_report),
        .nack_i      (nack_err),
        .misc_err_i  (misc_err),
        .halt_ack_i  (halt_ack),
        .rst_done_i  (rst_done),
        .mask_we_i   (mask_we),
        .mask_data_i (mask_wdata),
        .clr_we_i    (clr_we),
        .clr_data_i  (clr_wdata),
        .gclr_we_i   (gclr_we),
        .gclr_bit_i  (gclr_bit),
        .status_o    (status),
        .irq_o       (irq)
    );

    a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    a_r12_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        !status[3] && !status[15] && !status[31]);

endmodule

// File: tb/evc_ctrl_bench.sv
`timescale 1ns/1ps
module evc_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_we = 0, clr_we = 0, gclr_we = 0, gclr_bit = 0, halt_we = 0, rst_we = 0;
    logic [31:0] mask_wdata = '0, clr_wdata = '0, rst_wdata = '0;
    logic [1:0]  halt_wdata = '0, rd_done = '0, eng_idle = '0;
    logic [3:0]  q_report = '0, nack_err = '0;
    logic [15:0] misc_err = '0;
    logic [1:0]  halt_req;
    logic [31:0] blk_reset, status;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    evc_ctrl u_evc_ctrl (.*);

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clean();
        eng_idle = 2'b11; cyc(2);
        gclr_we = 1; gclr_bit = 1; cyc();
        gclr_we = 0; gclr_bit = 0; eng_idle = 2'b00;
        mask_we = 1; mask_wdata = '0; cyc();
        mask_we = 0;
    endtask

    task automatic t_reset_state();
        chk("reset status", status, 32'h0);
        chk("reset irq", {31'h0, irq}, 32'h0);
        chk("reset halt_req", {30'h0, halt_req}, 32'h0);
        chk("reset blk_reset", blk_reset, 32'h0);
    endtask

    task automatic t_events_and_clear();
        rd_done = 2'b11; q_report = 4'b1111; cyc();
        rd_done = '0; q_report = '0;
        chk("R1 read and report bits", status, 32'h0011_1111);
        clr_we = 1; clr_wdata = 32'h0000_0011; cyc();
        clr_we = 0;
        chk("R3 partial clear", status, 32'h0011_1100);
        clr_we = 1; clr_wdata = 32'h0011_1100; cyc();
        clr_we = 0;
        chk("R3 full clear", status, 32'h0);
    endtask

    task automatic t_faults();
        nack_err = 4'b0001; cyc();
        nack_err = '0;
        chk("R2 nack engine0 queue0 bit 27", status, 32'h0800_0000);
        chk("R9 fault halts engine0", {30'h0, halt_req}, 32'h1);
        misc_err = 16'h0100; cyc();
        misc_err = '0;
        chk("R1 engine1 misc fault 0 at bit 13", status, 32'h0800_2000);
        chk("R9 fault halts engine1", {30'h0, halt_req}, 32'h3);
        misc_err = 16'h00ff; nack_err = 4'b1110; cyc();
        misc_err = '0; nack_err = '0;
        chk("R1 R2 engine0 misc and remaining nacks", status, 32'h7800_2ee6);
        gclr_we = 1; gclr_bit = 0; cyc();
        gclr_we = 0;
        chk("R5 global clear with 0 ignored", status, 32'h7800_2ee6);
        eng_idle = 2'b11; cyc();
        eng_idle = 2'b00;
        chk("R7 both halts acknowledged", status, 32'h7e00_2ee6);
        chk("R7 halt requests dropped", {30'h0, halt_req}, 32'h0);
        gclr_we = 1; gclr_bit = 1; cyc();
        gclr_we = 0; gclr_bit = 0;
        chk("R5 global clear empties word", status, 32'h0);
    endtask

    task automatic t_all_at_once();
        eng_idle = 2'b11;
        rd_done = 2'b11; q_report = '1; nack_err = '1; misc_err = '1; cyc();
        rd_done = '0; q_report = '0; nack_err = '0; misc_err = '0;
        chk("R1 R2 every event", status, 32'h78ff_7ff7);
        cyc();
        chk("R12 reserved bits stay zero with acks", status, 32'h7eff_7ff7);
        clean();
    endtask

    task automatic t_set_wins();
        rd_done = 2'b01; cyc();
        clr_we = 1; clr_wdata = 32'h1; cyc();
        rd_done = 2'b00; clr_we = 0;
        chk("R4 set and clear same cycle keeps bit", status, 32'h1);
        clr_we = 1; clr_wdata = 32'h1; q_report = 4'b0001; cyc();
        clr_we = 0; q_report = '0;
        chk("R4 other bit set while bit 0 cleared", status, 32'h10);
        gclr_we = 1; gclr_bit = 1; rd_done = 2'b10; cyc();
        gclr_we = 0; gclr_bit = 0; rd_done = '0;
        chk("R5 R4 event survives global clear", status, 32'h1000);
        clean();
    endtask

    task automatic t_irq();
        rd_done = 2'b01; cyc();
        rd_done = '0;
        chk("R6 disabled bit no irq", {31'h0, irq}, 32'h0);
        mask_we = 1; mask_wdata = 32'h10; cyc();
        mask_we = 0;
        chk("R6 other enable no irq", {31'h0, irq}, 32'h0);
        mask_we = 1; mask_wdata = 32'h11; cyc();
        mask_we = 0;
        chk("R6 enabled bit raises irq", {31'h0, irq}, 32'h1);
        clr_we = 1; clr_wdata = 32'h1; cyc();
        clr_we = 0;
        chk("R6 irq low after clear", {31'h0, irq}, 32'h0);
        clean();
    endtask

    task automatic t_halt();
        halt_we = 1; halt_wdata = 2'b01; cyc();
        halt_we = 0; halt_wdata = '0;
        chk("R7 halt request raised", {30'h0, halt_req}, 32'h1);
        cyc(3);
        chk("R7 request held while busy", {30'h0, halt_req}, 32'h1);
        chk("R7 no ack while busy", status, 32'h0);
        eng_idle = 2'b01; cyc();
        chk("R7 ack bit 25", status, 32'h0200_0000);
        chk("R7 request dropped", {30'h0, halt_req}, 32'h0);
        clean();
        eng_idle = 2'b11;
        halt_we = 1; halt_wdata = 2'b10; cyc();
        halt_we = 0; halt_wdata = '0;
        chk("R8 idle engine request seen", {30'h0, halt_req}, 32'h2);
        cyc();
        chk("R8 idle engine ack bit 26", status, 32'h0400_0000);
        chk("R8 idle engine request dropped", {30'h0, halt_req}, 32'h0);
        clean();
    endtask

    task automatic t_reset_cmd();
        rst_we = 1; rst_wdata = 32'hffff_ffff; cyc();
        rst_we = 0;
        chk("R10 no pulse one edge after write", blk_reset, 32'h0);
        cyc();
        chk("R10 pulse filtered to valid bits", blk_reset, 32'h0f73_f3f7);
        chk("R10 done not yet set", status, 32'h0);
        cyc();
        chk("R10 pulse lasts one cycle", blk_reset, 32'h0);
        chk("R10 reset done bit 24", status, 32'h0100_0000);
        clean();
        rst_we = 1; rst_wdata = 32'hf000_0008; cyc();
        rst_we = 0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 invalid-only command no pulse", blk_reset, 32'h0);
            cyc();
        end
        chk("R10 invalid-only command no done", status, 32'h0);
    endtask

    task automatic t_reset_defer();
        halt_we = 1; halt_wdata = 2'b01; cyc();
        halt_we = 0; halt_wdata = '0;
        rst_we = 1; rst_wdata = 32'h0003_f001; cyc();
        rst_we = 0; cyc();
        chk("R11 other engine reset not held", blk_reset, 32'h0003_f001);
        cyc();
        rst_we = 1; rst_wdata = 32'h0000_03f1; cyc();
        rst_we = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R11 reset held while halt pending", blk_reset, 32'h0);
            cyc();
        end
        eng_idle = 2'b01; cyc();
        chk("R11 halt acked, still no pulse", blk_reset, 32'h0);
        cyc();
        chk("R11 held reset applied after ack", blk_reset, 32'h0000_03f1);
        clean();
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc();
        t_reset_state();
        t_events_and_clear();
        t_faults();
        t_all_at_once();
        t_set_wins();
        t_irq();
        t_halt();
        t_reset_cmd();
        t_reset_defer();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule